// File: doc/BRIEF.md
# Seat Belt Reminder Controller

This block watches an ignition level and a belt-fastened level and raises an alarm when the driver turns the ignition on and leaves the belt open for too long. It is a three-state sequential controller: idle, waiting and alarming. An elapsed-time counter is cleared when the ignition turns on. It advances by one on each cycle where the time-unit tick is high.

Once the count reaches the first threshold while the driver still waits unbelted, the alarm sounds. The alarm goes quiet again when the belt is fastened, when the ignition goes off, or when the count reaches the second threshold. After a timeout, the ignition must be switched off and on again before the machine can leave idle. The time base, input debouncing and the buzzer driver sit outside this block.

Top module: `seatbelt_reminder`

## Requirements
- R1: While `rst_n` is low the alarm is low and the machine is idle; an assertion of `rst_n` low clears an active alarm without waiting for a clock edge.
- R2: From idle, a rising edge of `ign_on` (high on this edge, low on the previous one) moves the machine to waiting and clears the elapsed count to 0 on the same edge, even if `time_tick` is high on that edge.
- R3: In waiting, `ign_on` low or `belt_fastened` high on an edge returns the machine to idle with the alarm left low.
- R4: In waiting, with the ignition on and the belt open, the edge that sees the count equal to ALARM_AT (default 5) enters alarming; with a tick on every cycle the alarm is high after edge 6 counted from the key-on edge (edge 0).
- R5: In alarming, the edge that sees the count equal to QUIET_AT (default 10) returns to idle and drops the alarm; with a tick on every cycle the alarm is low again after edge 11.
- R6: In alarming, `belt_fastened` high or `ign_on` low on an edge returns to idle and drops the alarm on that edge.
- R7: A belt or key-off exit seen on the same edge as a threshold wins: the machine goes to idle and the alarm does not rise.
- R8: After a timeout with `ign_on` held high the machine stays idle, with the alarm low, until `ign_on` goes low and then high again.
- R9: The count advances only on edges where `time_tick` is high, and it saturates at its maximum value rather than wrapping; with a tick every p cycles the alarm covers edges 5p+1 up to 10p.
- R10: `alarm` is a registered output that is high exactly while the machine is in the alarming state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ign_on | input | 1 | Ignition key level, high when on |
| belt_fastened | input | 1 | Seat belt level, high when latched |
| time_tick | input | 1 | One-cycle pulse per elapsed time unit |
| alarm | output | 1 | Registered alarm request |

## Verification
The hardest situations to reach are a belt or key-off event that lands on exactly the same edge as a threshold, and the timed-out idle state with the key still on. The bench sweeps the tick period, the belt edge and the key-off edge over every position around both thresholds. It computes the expected alarm window arithmetically from those positions. A directed run then holds the key past the timeout and toggles it to show that re-arming needs a fresh key-on edge.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [1:0] {
    SBR_IDLE  = 2'd0,
    SBR_WAIT  = 2'd1,
    SBR_ALARM = 2'd2
  } sbr_state_e;

endpackage

// File: rtl/sbr_key_edge.sv
module sbr_key_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ign_on,
  output logic key_prev,
  output logic key_rise
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= ign_on;
    end
  end

  assign key_prev = prev_q;
  assign key_rise = ign_on & ~prev_q;

endmodule

// File: rtl/sbr_timer.sv
module sbr_timer #(
  parameter int CNT_W    = 4,
  parameter int ALARM_AT = 5,
  parameter int QUIET_AT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             hit_alarm,
  output logic             hit_quiet
);

  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ALARM_LIM = CNT_W'(ALARM_AT);
  localparam logic [CNT_W-1:0] QUIET_LIM = CNT_W'(QUIET_AT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = clr | (tick & (cnt_q != CNT_MAX));

  always_comb begin
    if (clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count     = cnt_q;
  assign hit_alarm = (cnt_q >= ALARM_LIM);
  assign hit_quiet = (cnt_q >= QUIET_LIM);

endmodule

// File: rtl/sbr_fsm.sv
module sbr_fsm
  import sbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_rise,
  input  logic       ign_on,
  input  logic       belt_fastened,
  input  logic       hit_alarm,
  input  logic       hit_quiet,
  output sbr_state_e state,
  output logic       alarm
);

  sbr_state_e state_q;
  sbr_state_e state_d;
  logic       alarm_q;
  logic       quit;

  assign quit = belt_fastened | ~ign_on;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SBR_IDLE: begin
        if (key_rise) state_d = SBR_WAIT;
      end
      SBR_WAIT: begin
        if (quit)           state_d = SBR_IDLE;
        else if (hit_alarm) state_d = SBR_ALARM;
      end
      SBR_ALARM: begin
        if (quit || hit_quiet) state_d = SBR_IDLE;
      end
      default: state_d = SBR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SBR_IDLE;
      alarm_q <= 1'b0;
    end else begin
      state_q <= state_d;
      alarm_q <= (state_d == SBR_ALARM);
    end
  end

  assign state = state_q;
  assign alarm = alarm_q;

endmodule

// File: rtl/seatbelt_reminder.sv
module seatbelt_reminder
  import sbr_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int ALARM_AT = 5,
  parameter int QUIET_AT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ign_on,
  input  logic belt_fastened,
  input  logic time_tick,
  output logic alarm
);

  logic             key_prev;
  logic             key_rise;
  logic [CNT_W-1:0] count;
  logic             hit_alarm;
  logic             hit_quiet;
  sbr_state_e       state;

  sbr_key_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .ign_on   (ign_on),
    .key_prev (key_prev),
    .key_rise (key_rise)
  );

  sbr_timer #(
    .CNT_W    (CNT_W),
    .ALARM_AT (ALARM_AT),
    .QUIET_AT (QUIET_AT)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (key_rise),
    .tick      (time_tick),
    .count     (count),
    .hit_alarm (hit_alarm),
    .hit_quiet (hit_quiet)
  );

  sbr_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .key_rise      (key_rise),
    .ign_on        (ign_on),
    .belt_fastened (belt_fastened),
    .hit_alarm     (hit_alarm),
    .hit_quiet     (hit_quiet),
    .state         (state),
    .alarm         (alarm)
  );

endmodule

// File: rtl/sbr_checker.sv
module sbr_checker
  import sbr_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int ALARM_AT = 5,
  parameter int QUIET_AT = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ign_on,
  input logic             belt_fastened,
  input logic             time_tick,
  input logic             alarm,
  input logic             key_prev,
  input logic [CNT_W-1:0] count,
  input sbr_state_e       state
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R10
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SBR_IDLE) || (state == SBR_WAIT) || (state == SBR_ALARM));

  // R10
  alarm_matches_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm == (state == SBR_ALARM));

  // R2
  key_on_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SBR_IDLE && ign_on && !key_prev) |=> (state == SBR_WAIT && count == '0));

  // R3
  wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SBR_WAIT && (!ign_on || belt_fastened)) |=> (state == SBR_IDLE && !alarm));

  // R4
  alarm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> ($past(state) == SBR_WAIT && $past(count) >= CNT_W'(ALARM_AT)));

  // R5
  quiet_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && count >= CNT_W'(QUIET_AT)) |=> !alarm);

  // R6
  alarm_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && (belt_fastened || !ign_on)) |=> !alarm);

  // R8
  no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SBR_IDLE && key_prev) |=> (state == SBR_IDLE));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CMAX && !(ign_on && !key_prev)) |=> (count == CMAX));

  // R9
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!time_tick && !(ign_on && !key_prev)) |=> $stable(count));

endmodule

bind seatbelt_reminder sbr_checker #(
  .CNT_W    (CNT_W),
  .ALARM_AT (ALARM_AT),
  .QUIET_AT (QUIET_AT)
) u_sbr_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .ign_on        (ign_on),
  .belt_fastened (belt_fastened),
  .time_tick     (time_tick),
  .alarm         (alarm),
  .key_prev      (key_prev),
  .count         (count),
  .state         (state)
);

// File: tb/test_seatbelt_reminder.sv
`timescale 1ns/1ps
module test_seatbelt_reminder;

  logic clk;
  logic rst_n;
  logic ign_on;
  logic belt_fastened;
  logic time_tick;
  logic alarm;

  int n_checks;
  int n_errors;
  bit done;

  seatbelt_reminder i_seatbelt_reminder (
    .clk           (clk),
    .rst_n         (rst_n),
    .ign_on        (ign_on),
    .belt_fastened (belt_fastened),
    .time_tick     (time_tick),
    .alarm         (alarm)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp, input int where);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s at step %0d: alarm actual=%b expected=%b", req, where, act, exp);
    end
  endtask

  task automatic idle_gap();
    ign_on = 1'b0; belt_fastened = 1'b0; time_tick = 1'b0;
    repeat (3) @(negedge clk);
    check("R3", alarm, 1'b0, -1);
  endtask

  // Key-on seen at edge 0; tick on edges that are multiples of p;
  // belt seen from edge b, key low from edge off (-1 = never).
  task automatic run_scn(input int p, input int b, input int off);
    int lo, hi, last;
    string tag;
    lo = 5 * p + 1;
    hi = 10 * p + 1;
    last = hi + 4;
    if (b >= 0 && b < hi) hi = b;
    if (off >= 0 && off < hi) hi = off;
    ign_on = 1'b1; belt_fastened = 1'b0; time_tick = 1'b1;
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      if ((b >= 0 && b == 5 * p + 1) || (off >= 0 && off == 5 * p + 1)) tag = "R7";
      else if (hi < 5 * p + 1 && k >= hi) tag = "R3";
      else if (k < 5 * p + 1) tag = (p > 1) ? "R9" : "R2";
      else if (k == 5 * p + 1) tag = "R4";
      else if (hi < 10 * p + 1) tag = "R6";
      else tag = "R5";
      check(tag, alarm, (k >= lo && k < hi), k);
      time_tick     = ((k + 1) % p == 0);
      belt_fastened = (b >= 0 && k + 1 >= b);
      ign_on        = !(off >= 0 && k + 1 >= off);
    end
    idle_gap();
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_errors = 0; done = 0;
    rst_n = 1'b0; ign_on = 1'b1; belt_fastened = 1'b0; time_tick = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", alarm, 1'b0, 0);
    ign_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle_gap();

    for (int p = 1; p <= 3; p++) begin
      int pts[8];
      pts = '{-1, 1, 3, 5 * p, 5 * p + 1, 5 * p + 2, 10 * p, 10 * p + 1};
      for (int i = 0; i < 8; i++) run_scn(p, pts[i], -1);
      for (int i = 1; i < 8; i++) run_scn(p, -1, pts[i]);
      run_scn(p, 5 * p + 1, 5 * p + 1);
    end

    // R8: hold the key past timeout, then re-arm with a fresh key-on edge
    ign_on = 1'b1; time_tick = 1'b1; belt_fastened = 1'b0;
    for (int k = 0; k <= 40; k++) begin
      @(negedge clk);
      check("R8", alarm, (k >= 6 && k < 11), k);
    end
    ign_on = 1'b0;
    @(negedge clk);
    check("R8", alarm, 1'b0, 41);
    ign_on = 1'b1;
    for (int k = 0; k <= 8; k++) begin
      @(negedge clk);
      check("R8", alarm, (k >= 6), k);
    end

    // R1: asynchronous reset while the alarm is on
    #1 rst_n = 1'b0;
    #0.5 check("R1", alarm, 1'b0, 0);
    @(negedge clk);
    check("R1", alarm, 1'b0, 1);
    ign_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle_gap();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule